// File: doc/BRIEF.md
# Mixed-Polarity Feedback Shift Register

This block is a configurable N-stage shift register for built-in self test. Software-free and purely hardware controlled, it either produces a pseudorandom serial stream from its last stage (generator mode) or folds a stream of parallel response words into a signature held in the register (analyzer mode). The structure is an internal-XOR (Galois) feedback register. Unlike a plain linear register, each link from one stage to the next can pass the true or the complemented bit, chosen by a per-link mask. The input of the first stage can also be complemented. These choices widen the set of sequences and signatures that a given polynomial can reach.

The register is cleared by reset and written by a synchronous seed load, which wins over the enable. While enable is high, it steps once per clock. The tap vector, the link mask and the head-invert bit are static configuration and may change only while enable is low. Appending an extra arbitrary word after the response stream is an ordinary analyzer step, so a dummy word can be added before the signature is read.

Top module: `pfsr_top`

## Requirements
- R1: While reset is low, state_o reads all zeros and serial_o reads 0, and this holds on the first cycle after reset is released.
- R2: When load_i is high at a clock edge, state_o equals seed_i after that edge, whatever enable_i and mode_i are.
- R3: When load_i and enable_i are both low at an edge, state_o keeps its value, even if resp_i or mode_i change.
- R4: With enable_i high, load_i low and mode_i = 0 (generator), one step gives next[0] = s[N-1] XOR head_inv_i and, for i from 1 to N-1, next[i] = (s[i-1] XOR flip_mask_i[i]) XOR (taps_i[i] AND s[N-1]). Here s is the value before the edge. Configuration is held stable while enable_i is high.
- R5: With flip_mask_i[N-1:1] all zero and head_inv_i = 0, the generator sequence equals that of a plain internal-XOR LFSR with the same taps.
- R6: With mode_i = 1 (analyzer), each step is the R4 step with resp_i[i] additionally XORed into next[i] for every i. A word appended after the stream is compacted like any other word. In generator mode, resp_i has no effect.
- R7: serial_o always equals state_o[N-1]. Both are registered and show a step's result from the clock edge that performs it.
- R8: flip_mask_i[0] and taps_i[0] have no effect: stage 0 always receives the feedback bit, and it has no incoming link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Synchronous seed write, priority over enable |
| seed_i | input | N | Seed value |
| enable_i | input | 1 | Step the register this cycle |
| mode_i | input | 1 | 0 = pattern generator, 1 = signature analyzer |
| taps_i | input | N | Feedback taps; bit i adds feedback into stage i |
| flip_mask_i | input | N | Bit i complements the link from stage i-1 to stage i |
| head_inv_i | input | 1 | Complement the first stage's input |
| resp_i | input | N | Parallel response word (analyzer mode) |
| serial_o | output | 1 | Last-stage bit |
| state_o | output | N | Register contents (pattern state or signature) |

## Verification
The bench sets random link masks, taps and head-invert values, with bit 0 of mask and taps also set, against a step model. A design that complemented the wrong link, or used bit 0 of the mask, would diverge within a few steps. Runs with an all-zero mask are compared to a plain LFSR function, which catches any polarity applied when none is asked for. Analyzer runs feed random words with gaps in enable and then append a dummy word. A design that dropped resp_i in analyzer mode, let it leak in generator mode, or stepped while idle would end with a different signature. Seed load with enable also high, and a reset in the middle of a run, catch wrong priority and a reset that does not clear the register.

// File: rtl/pfsr_pkg.sv
package pfsr_pkg;

    typedef enum logic {
        PFSR_GEN     = 1'b0,
        PFSR_COMPACT = 1'b1
    } pfsr_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SEED = 2'd1,
        ACT_STEP = 2'd2
    } pfsr_act_e;

endpackage

// File: rtl/pfsr_ctrl.sv
module pfsr_ctrl
    import pfsr_pkg::*;
(
    input  logic      load_i,
    input  logic      enable_i,
    output pfsr_act_e act_o
);

    // Seed load wins over stepping.
    always_comb begin
        if (load_i) begin
            act_o = ACT_SEED;
        end else if (enable_i) begin
            act_o = ACT_STEP;
        end else begin
            act_o = ACT_HOLD;
        end
    end

endmodule

// File: rtl/pfsr_head.sv
module pfsr_head (
    input  logic fb_i,
    input  logic head_inv_i,
    input  logic resp_bit_i,
    input  logic compact_i,
    output logic next_o
);

    logic fed;

    always_comb begin
        fed    = head_inv_i ? ~fb_i : fb_i;
        next_o = fed ^ (compact_i & resp_bit_i);
    end

endmodule

// File: rtl/pfsr_link.sv
module pfsr_link (
    input  logic prev_i,
    input  logic flip_i,
    input  logic tap_i,
    input  logic fb_i,
    input  logic resp_bit_i,
    input  logic compact_i,
    output logic next_o
);

    logic passed;

    // Polarity is applied to the shifted bit before the feedback and
    // response XORs.
    always_comb begin
        passed = flip_i ? ~prev_i : prev_i;
        next_o = passed ^ (tap_i & fb_i) ^ (compact_i & resp_bit_i);
    end

endmodule

// File: rtl/pfsr_step.sv
module pfsr_step #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] taps_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic             head_inv_i,
    input  logic [WIDTH-1:0] resp_i,
    input  logic             compact_i,
    output logic [WIDTH-1:0] nxt_o
);

    localparam int LAST = WIDTH - 1;

    logic fb;
    logic unused_bit0;

    assign fb          = cur_i[LAST];
    // Stage 0 has no incoming link and always takes the feedback.
    assign unused_bit0 = taps_i[0] ^ mask_i[0];

    pfsr_head head_i (
        .fb_i       (fb),
        .head_inv_i (head_inv_i),
        .resp_bit_i (resp_i[0]),
        .compact_i  (compact_i),
        .next_o     (nxt_o[0])
    );

    for (genvar i = 1; i < WIDTH; i++) begin : g_link
        pfsr_link link_i (
            .prev_i     (cur_i[i-1]),
            .flip_i     (mask_i[i]),
            .tap_i      (taps_i[i]),
            .fb_i       (fb),
            .resp_bit_i (resp_i[i]),
            .compact_i  (compact_i),
            .next_o     (nxt_o[i])
        );
    end

endmodule

// File: rtl/pfsr_top.sv
module pfsr_top
    import pfsr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic             enable_i,
    input  logic             mode_i,
    input  logic [WIDTH-1:0] taps_i,
    input  logic [WIDTH-1:0] flip_mask_i,
    input  logic             head_inv_i,
    input  logic [WIDTH-1:0] resp_i,
    output logic             serial_o,
    output logic [WIDTH-1:0] state_o
);

    localparam int LAST = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } pfsr_state_t;

    pfsr_state_t st_d, st_q;
    pfsr_act_e   act;
    pfsr_mode_e  mode;
    logic        compact;
    logic [WIDTH-1:0] step_nxt;

    assign mode    = pfsr_mode_e'(mode_i);
    assign compact = (mode == PFSR_COMPACT);

    pfsr_ctrl ctrl_i (
        .load_i   (load_i),
        .enable_i (enable_i),
        .act_o    (act)
    );

    pfsr_step #(.WIDTH(WIDTH)) step_i (
        .cur_i      (st_q.sr),
        .taps_i     (taps_i),
        .mask_i     (flip_mask_i),
        .head_inv_i (head_inv_i),
        .resp_i     (resp_i),
        .compact_i  (compact),
        .nxt_o      (step_nxt)
    );

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_SEED: st_d.sr = seed_i;
            ACT_STEP: st_d.sr = step_nxt;
            default:  st_d    = st_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o  = st_q.sr;
    assign serial_o = st_q.sr[LAST];

endmodule

// File: rtl/pfsr_chk.sv
module pfsr_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             load_i,
    input logic [WIDTH-1:0] seed_i,
    input logic             enable_i,
    input logic             mode_i,
    input logic [WIDTH-1:0] taps_i,
    input logic [WIDTH-1:0] flip_mask_i,
    input logic             head_inv_i,
    input logic [WIDTH-1:0] resp_i,
    input logic             serial_o,
    input logic [WIDTH-1:0] state_o
);

    localparam int LAST = WIDTH - 1;

    assert_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (state_o == '0));

    assert_seed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (state_o == $past(seed_i)));

    assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !enable_i) |=> $stable(state_o));

    // R4 and R6: stage 0 takes feedback, head invert and response bit 0.
    assert_head_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !load_i) |=>
        (state_o[0] == ($past(state_o[LAST]) ^ $past(head_inv_i)
                        ^ ($past(mode_i) & $past(resp_i[0])))));

    assert_cfg_static_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && $past(enable_i)) |->
        ($stable(taps_i) && $stable(flip_mask_i) && $stable(head_inv_i)));

    assert_plain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !load_i && !mode_i && !head_inv_i
         && (flip_mask_i[LAST:1] == '0)) |=>
        (state_o[LAST:1] == ($past(state_o[LAST-1:0])
            ^ ($past(state_o[LAST]) ? $past(taps_i[LAST:1]) : '0))));

    always_comb begin
        if (rst_ni) begin
            assert_serial_R7: assert (serial_o == state_o[LAST]);
        end
    end

endmodule

bind pfsr_top pfsr_chk #(.WIDTH(WIDTH)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .seed_i      (seed_i),
    .enable_i    (enable_i),
    .mode_i      (mode_i),
    .taps_i      (taps_i),
    .flip_mask_i (flip_mask_i),
    .head_inv_i  (head_inv_i),
    .resp_i      (resp_i),
    .serial_o    (serial_o),
    .state_o     (state_o)
);

// File: tb/pfsr_top_tb_top.sv
module pfsr_top_tb_top;

    localparam int W        = 16;
    localparam int CLK_HALF = 5;

    logic         clk = 1'b0;
    logic         rst_ni = 1'b0;
    logic         load_i = 1'b0;
    logic [W-1:0] seed_i = '0;
    logic         enable_i = 1'b0;
    logic         mode_i = 1'b0;
    logic [W-1:0] taps_i = '0;
    logic [W-1:0] flip_mask_i = '0;
    logic         head_inv_i = 1'b0;
    logic [W-1:0] resp_i = '0;
    logic         serial_o;
    logic [W-1:0] state_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #CLK_HALF clk = ~clk;

    pfsr_top #(.WIDTH(W)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .load_i      (load_i),
        .seed_i      (seed_i),
        .enable_i    (enable_i),
        .mode_i      (mode_i),
        .taps_i      (taps_i),
        .flip_mask_i (flip_mask_i),
        .head_inv_i  (head_inv_i),
        .resp_i      (resp_i),
        .serial_o    (serial_o),
        .state_o     (state_o)
    );

    // Spec step: stage 0 <- fb ^ inv (^resp0), stage i <- s[i-1]^mask[i]^tap&fb (^resp i).
    function automatic logic [W-1:0] model_step(logic [W-1:0] s, logic [W-1:0] tp,
                                                logic [W-1:0] mk, logic inv,
                                                logic cmp, logic [W-1:0] rs);
        logic [W-1:0] n;
        logic fb;
        fb   = s[W-1];
        n[0] = fb ^ inv ^ (cmp & rs[0]);
        for (int i = 1; i < W; i++) begin
            n[i] = s[i-1] ^ mk[i] ^ (tp[i] & fb) ^ (cmp & rs[i]);
        end
        return n;
    endfunction

    // Plain internal-XOR LFSR, written independently.
    function automatic logic [W-1:0] plain_lfsr(logic [W-1:0] s, logic [W-1:0] tp);
        logic [W-1:0] sh;
        sh = {s[W-2:0], 1'b0};
        if (s[W-1]) sh = sh ^ {tp[W-1:1], 1'b1};
        return sh;
    endfunction

    task automatic check_val(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Inputs set just after a negedge; outputs sampled at the next negedge.
    task automatic cyc(logic ld, logic [W-1:0] sd, logic en, logic md, logic [W-1:0] rs);
        load_i   = ld;
        seed_i   = sd;
        enable_i = en;
        mode_i   = md;
        resp_i   = rs;
        @(negedge clk);
    endtask

    task automatic set_cfg(logic [W-1:0] tp, logic [W-1:0] mk, logic inv);
        enable_i    = 1'b0;
        taps_i      = tp;
        flip_mask_i = mk;
        head_inv_i  = inv;
    endtask

    task automatic run_random(string req, int steps, logic md, logic plain);
        logic [W-1:0] exp;
        logic [W-1:0] sd;
        logic [W-1:0] tp;
        logic [W-1:0] mk;
        logic inv;
        tp  = W'($urandom);
        mk  = plain ? '0 : W'($urandom);
        inv = plain ? 1'b0 : 1'($urandom);
        sd  = W'($urandom);
        set_cfg(tp, mk, inv);
        cyc(1'b1, sd, 1'b0, md, '0);
        exp = sd;
        check_val("R2 seed", state_o, exp);
        for (int k = 0; k < steps; k++) begin
            logic en;
            logic [W-1:0] rs;
            en = ($urandom % 4) != 0;
            rs = W'($urandom);
            cyc(1'b0, W'($urandom), en, md, rs);
            if (en) exp = plain ? plain_lfsr(exp, tp) : model_step(exp, tp, mk, inv, md, rs);
            check_val(req, state_o, exp);
            check_val("R7 serial", {{(W-1){1'b0}}, serial_o}, {{(W-1){1'b0}}, exp[W-1]});
        end
        enable_i = 1'b0;
    endtask

    initial begin
        logic [W-1:0] exp;
        logic [W-1:0] rs;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check_val("R1 reset state", state_o, '0);
        check_val("R1 reset serial", {{(W-1){1'b0}}, serial_o}, '0);
        rst_ni = 1'b1;
        @(negedge clk);
        check_val("R1 after release", state_o, '0);

        // R2: load has priority over enable, in analyzer mode too
        set_cfg(16'h002D, 16'h0000, 1'b0);
        cyc(1'b1, 16'hA5C3, 1'b1, 1'b1, 16'hFFFF);
        check_val("R2 load beats enable", state_o, 16'hA5C3);

        // R3: hold while idle with changing response and mode
        cyc(1'b0, 16'h1111, 1'b0, 1'b1, 16'h7E7E);
        cyc(1'b0, 16'h2222, 1'b0, 1'b0, 16'h0F0F);
        check_val("R3 hold", state_o, 16'hA5C3);

        // R4 directed: all-ones mask with head invert, from zero
        set_cfg(16'h0000, 16'hFFFF, 1'b1);
        cyc(1'b1, 16'h0000, 1'b0, 1'b0, '0);
        cyc(1'b0, '0, 1'b1, 1'b0, '0);
        check_val("R4 all-flip step", state_o, 16'hFFFF);

        // R8: bit 0 of taps and mask ignored
        set_cfg(16'h0001, 16'h0001, 1'b0);
        cyc(1'b1, 16'h8000, 1'b0, 1'b0, '0);
        cyc(1'b0, '0, 1'b1, 1'b0, '0);
        check_val("R8 bit0 ignored", state_o, 16'h0001);

        // R6: response ignored in generator mode (single directed step)
        set_cfg(16'h1021, 16'h0000, 1'b0);
        cyc(1'b1, 16'h0003, 1'b0, 1'b0, '0);
        cyc(1'b0, '0, 1'b1, 1'b0, 16'hFFFF);
        check_val("R6 resp ignored in gen", state_o, 16'h0006);

        // R1: reset in the middle of activity
        cyc(1'b1, 16'hBEEF, 1'b0, 1'b0, '0);
        rst_ni = 1'b0;
        #1;
        check_val("R1 async reset", state_o, '0);
        @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);

        for (int t = 0; t < 6; t++) run_random("R5 plain lfsr", 40, 1'b0, 1'b1);
        for (int t = 0; t < 20; t++) run_random("R4 gen step", 40, 1'b0, 1'b0);
        for (int t = 0; t < 20; t++) run_random("R6 compact step", 40, 1'b1, 1'b0);

        // R6: signature then appended dummy word
        set_cfg(16'h8805, 16'h5A3C, 1'b1);
        cyc(1'b1, 16'h1357, 1'b0, 1'b1, '0);
        exp = 16'h1357;
        for (int k = 0; k < 32; k++) begin
            rs = W'($urandom);
            cyc(1'b0, '0, 1'b1, 1'b1, rs);
            exp = model_step(exp, 16'h8805, 16'h5A3C, 1'b1, 1'b1, rs);
        end
        check_val("R6 signature", state_o, exp);
        rs = W'($urandom);
        cyc(1'b0, '0, 1'b1, 1'b1, rs);
        exp = model_step(exp, 16'h8805, 16'h5A3C, 1'b1, 1'b1, rs);
        check_val("R6 dummy word", state_o, exp);
        cyc(1'b0, '0, 1'b0, 1'b1, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule